// File: doc/BRIEF.md
# Cache control and statistics unit

This unit is the control plane for an instruction cache and its companion line buffer. Software writes a control word through a single write port. The word enables the cache and the line buffer, requests flushes, selects the replacement policy and governs two statistics counters. The cache datapath reports hits and misses as one-cycle pulses. The unit counts them in two saturating counters. It drives enable levels and one-cycle flush strobes to the cache, the line buffer and the secure-side cache.

A busy flag in the status word covers every change of state. After reset the flag stays high for a fixed settling period. Any flush or enable change sets the flag again, and it stays high until the cache returns a done pulse or a time-out expires. Writes that arrive while the flag is high are dropped and flagged with an error pulse.

Top module: `cache_ctl_unit`

## Requirements
- R1: During and right after reset, the control readback is 0x00000091: cache enable (bit 0) is 1, line-buffer enable (bit 4) is 1, policy (bit 6) is 0 and counter enable (bit 7) is 1. The status word is 2'b11 (bit 1 busy, bit 0 enabled), and both counters are 0.
- R2: A 1 written to a flush bit (bit 3 for the cache, bit 5 for the line buffer, bit 16 for the secure-side cache) produces a strobe on the matching output that is high for exactly one cycle, in the cycle after the write edge. The clear bit (bit 8) also acts once. These four bits always read back as 0, and writing 0 to any of them has no effect.
- R3: An accepted write that changes the cache enable from 1 to 0 also pulses the cache flush strobe. A write that changes the line-buffer enable from 1 to 0 also pulses the line-buffer flush strobe.
- R4: A write presented while status busy is 1 is refused. Nothing in the control word, the strobes or the counters changes, and wr_err_o is high for one cycle after that edge.
- R5: An accepted write that requests any flush, or changes either enable, sets busy from the next cycle. Busy clears on the edge where cache_done is seen high, or after TMO_CYC busy cycles without done. A write that does neither leaves busy at 0.
- R6: Each counter adds 1 for every cycle in which its event pulse is high and the counter enable is 1. The counters hold at all ones, 2^CNT_W-1, and never wrap. They hold their value while counter enable is 0.
- R7: An accepted write with bit 8 set clears both counters on that edge, and this takes priority over an increment in the same cycle.
- R8: After reset is released, busy remains 1 for exactly RST_CYC cycles, and cache_done is ignored during that time.
- R9: Status bit 0 and cache_en_o follow the cache enable bit. lb_en_o follows bit 4, and policy_o follows bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| ctrl_rdata | output | 32 | Control word readback |
| stat_o | output | 2 | Status: bit 1 busy, bit 0 cache enabled |
| wr_err_o | output | 1 | One-cycle pulse for a refused write |
| hit_pulse | input | 1 | Cache hit event |
| miss_pulse | input | 1 | Cache miss event |
| cache_done | input | 1 | Cache finished its state change |
| hit_cnt | output | CNT_W | Hit counter |
| miss_cnt | output | CNT_W | Miss counter |
| cache_en_o | output | 1 | Cache enable level |
| lb_en_o | output | 1 | Line-buffer enable level |
| policy_o | output | 1 | Replacement policy select |
| cache_flush_o | output | 1 | Cache flush strobe |
| lb_flush_o | output | 1 | Line-buffer flush strobe |
| sec_flush_o | output | 1 | Secure-side cache flush strobe |

## Verification
The bench builds the unit with CNT_W = 8, TMO_CYC = 16 and RST_CYC = 4. Narrow counters let a run of directed hits reach and hold the saturation value. A short time-out lets a flush that never gets its done pulse expire within a few cycles. Random writes land both inside and outside busy windows, so refusals and accepted writes are exercised next to each other.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  localparam int BIT_CEN = 0;
  localparam int BIT_CFL = 3;
  localparam int BIT_LEN = 4;
  localparam int BIT_LFL = 5;
  localparam int BIT_POL = 6;
  localparam int BIT_CNE = 7;
  localparam int BIT_CLR = 8;
  localparam int BIT_SFL = 16;
  localparam int NUM_EV  = 2;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_WAIT = 2'd2
  } seq_st_t;
endpackage

// File: rtl/ccu_ctrl_reg.sv
module ccu_ctrl_reg
  import ccu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        busy,
  output logic        en_q,
  output logic        lb_q,
  output logic        pol_q,
  output logic        cnten_q,
  output logic        cflush_q,
  output logic        lflush_q,
  output logic        sflush_q,
  output logic        err_q,
  output logic        clr_req,
  output logic        kick
);
  logic acc, n_en, n_lb, c_fl, l_fl, s_fl, chg;

  always_comb begin
    acc     = wr_en & ~busy;
    n_en    = wr_data[BIT_CEN];
    n_lb    = wr_data[BIT_LEN];
    c_fl    = acc & (wr_data[BIT_CFL] | (en_q & ~n_en));
    l_fl    = acc & (wr_data[BIT_LFL] | (lb_q & ~n_lb));
    s_fl    = acc & wr_data[BIT_SFL];
    chg     = acc & ((n_en ^ en_q) | (n_lb ^ lb_q));
    kick    = c_fl | l_fl | s_fl | chg;
    clr_req = acc & wr_data[BIT_CLR];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b1;
      lb_q     <= 1'b1;
      pol_q    <= 1'b0;
      cnten_q  <= 1'b1;
      cflush_q <= 1'b0;
      lflush_q <= 1'b0;
      sflush_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      cflush_q <= c_fl;
      lflush_q <= l_fl;
      sflush_q <= s_fl;
      err_q    <= wr_en & busy;
      if (acc) begin
        en_q    <= n_en;
        lb_q    <= n_lb;
        pol_q   <= wr_data[BIT_POL];
        cnten_q <= wr_data[BIT_CNE];
      end
    end
  end
endmodule

// File: rtl/ccu_seq.sv
module ccu_seq
  import ccu_pkg::*;
#(
  parameter int RST_CYC = 4,
  parameter int TMO_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  input  logic done,
  output logic busy_q
);
  localparam int MAXC = (RST_CYC > TMO_CYC) ? RST_CYC : TMO_CYC;
  localparam int TW   = $clog2(MAXC) + 1;

  seq_st_t        st;
  logic [TW-1:0]  tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_INIT;
      tmr    <= TW'(RST_CYC - 1);
      busy_q <= 1'b1;
    end else begin
      case (st)
        ST_INIT: begin
          if (tmr == '0) begin
            st     <= ST_IDLE;
            busy_q <= 1'b0;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_IDLE: begin
          if (kick) begin
            st     <= ST_WAIT;
            busy_q <= 1'b1;
            tmr    <= TW'(TMO_CYC - 1);
          end
        end
        ST_WAIT: begin
          if (done || tmr == '0) begin
            st     <= ST_IDLE;
            busy_q <= 1'b0;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        default: begin
          st     <= ST_IDLE;
          busy_q <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/ccu_sat_cnt.sv
module ccu_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (inc && (q != '1)) begin
      q <= q + 1'b1;
    end
  end
endmodule

// File: rtl/cache_ctl_unit.sv
module cache_ctl_unit
  import ccu_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int RST_CYC = 4,
  parameter int TMO_CYC = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      ctrl_rdata,
  output logic [1:0]       stat_o,
  output logic             wr_err_o,
  input  logic             hit_pulse,
  input  logic             miss_pulse,
  input  logic             cache_done,
  output logic [CNT_W-1:0] hit_cnt,
  output logic [CNT_W-1:0] miss_cnt,
  output logic             cache_en_o,
  output logic             lb_en_o,
  output logic             policy_o,
  output logic             cache_flush_o,
  output logic             lb_flush_o,
  output logic             sec_flush_o
);
  logic en_q, lb_q, pol_q, cnten_q, clr_req, kick, busy_q;
  logic [NUM_EV-1:0]       ev;
  logic [CNT_W-1:0]        cnt_q [NUM_EV];

  ccu_ctrl_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .busy     (busy_q),
    .en_q     (en_q),
    .lb_q     (lb_q),
    .pol_q    (pol_q),
    .cnten_q  (cnten_q),
    .cflush_q (cache_flush_o),
    .lflush_q (lb_flush_o),
    .sflush_q (sec_flush_o),
    .err_q    (wr_err_o),
    .clr_req  (clr_req),
    .kick     (kick)
  );

  ccu_seq #(.RST_CYC(RST_CYC), .TMO_CYC(TMO_CYC)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .kick   (kick),
    .done   (cache_done),
    .busy_q (busy_q)
  );

  assign ev = {miss_pulse, hit_pulse};

  for (genvar i = 0; i < NUM_EV; i++) begin : g_cnt
    ccu_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (clr_req),
      .inc (ev[i] & cnten_q),
      .q   (cnt_q[i])
    );
  end

  assign hit_cnt    = cnt_q[0];
  assign miss_cnt   = cnt_q[1];
  assign cache_en_o = en_q;
  assign lb_en_o    = lb_q;
  assign policy_o   = pol_q;
  assign stat_o     = {busy_q, en_q};

  always_comb begin
    ctrl_rdata          = '0;
    ctrl_rdata[BIT_CEN] = en_q;
    ctrl_rdata[BIT_LEN] = lb_q;
    ctrl_rdata[BIT_POL] = pol_q;
    ctrl_rdata[BIT_CNE] = cnten_q;
  end
endmodule

// File: rtl/ccu_chk.sv
module ccu_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       stat_o,
  input logic             wr_err_o,
  input logic [31:0]      ctrl_rdata,
  input logic [CNT_W-1:0] hit_cnt,
  input logic             cache_en_o,
  input logic             lb_en_o,
  input logic             cache_flush_o,
  input logic             lb_flush_o
);
  AST_ERR_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    wr_err_o |-> ($past(stat_o[1]) && $past(wr_en))); // R4
  AST_REFUSED_KEEPS_CTRL: assert property (@(posedge clk) disable iff (rst)
    (wr_en && stat_o[1]) |=> $stable(ctrl_rdata)); // R4
  AST_CFLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cache_flush_o |=> !cache_flush_o); // R2
  AST_CDIS_FLUSHES: assert property (@(posedge clk) disable iff (rst)
    $fell(cache_en_o) |-> cache_flush_o); // R3
  AST_LDIS_FLUSHES: assert property (@(posedge clk) disable iff (rst)
    $fell(lb_en_o) |-> lb_flush_o); // R3
  AST_FLUSH_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cache_flush_o || lb_flush_o) |-> stat_o[1]); // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (&hit_cnt) |=> ((&hit_cnt) || (hit_cnt == '0))); // R6
endmodule

bind cache_ctl_unit ccu_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .stat_o        (stat_o),
  .wr_err_o      (wr_err_o),
  .ctrl_rdata    (ctrl_rdata),
  .hit_cnt       (hit_cnt),
  .cache_en_o    (cache_en_o),
  .lb_en_o       (lb_en_o),
  .cache_flush_o (cache_flush_o),
  .lb_flush_o    (lb_flush_o)
);

// File: tb/tb_cache_ctl_unit.sv
module tb_cache_ctl_unit;
  localparam int CLK_PERIOD = 10;
  localparam int CW   = 8;
  localparam int TMO  = 16;
  localparam int RSTC = 4;
  localparam logic [CW-1:0] MAXV = '1;

  logic clk = 1'b0;
  logic rst, wr_en, hit_pulse, miss_pulse, cache_done;
  logic [31:0] wr_data, ctrl_rdata;
  logic [1:0] stat_o;
  logic wr_err_o, cache_en_o, lb_en_o, policy_o;
  logic cache_flush_o, lb_flush_o, sec_flush_o;
  logic [CW-1:0] hit_cnt, miss_cnt;

  int n_chk = 0, n_fail = 0;

  // bench model state
  logic m_en, m_lb, m_pol, m_cne, m_busy, m_init;
  logic m_cfl, m_lfl, m_sfl, m_err;
  int   m_tmr;
  logic [CW-1:0] m_hit, m_miss;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_ctl_unit #(.CNT_W(CW), .RST_CYC(RSTC), .TMO_CYC(TMO)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_rdata(ctrl_rdata), .stat_o(stat_o), .wr_err_o(wr_err_o),
    .hit_pulse(hit_pulse), .miss_pulse(miss_pulse), .cache_done(cache_done),
    .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .cache_en_o(cache_en_o),
    .lb_en_o(lb_en_o), .policy_o(policy_o), .cache_flush_o(cache_flush_o),
    .lb_flush_o(lb_flush_o), .sec_flush_o(sec_flush_o));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ctrl();
    logic [31:0] v;
    v = 32'h0;
    v[0] = m_en; v[4] = m_lb; v[6] = m_pol; v[7] = m_cne;
    return v;
  endfunction

  function automatic logic [CW-1:0] sat_inc(logic [CW-1:0] v);
    return (v == MAXV) ? v : v + 1'b1;
  endfunction

  task automatic check_all();
    chk("R1", "ctrl readback", ctrl_rdata, exp_ctrl());
    chk("R5", "busy", 32'(stat_o[1]), 32'(m_busy));
    chk("R9", "status enabled", 32'(stat_o[0]), 32'(m_en));
    chk("R9", "enable outputs", {29'b0, cache_en_o, lb_en_o, policy_o},
        {29'b0, m_en, m_lb, m_pol});
    chk("R6", "hit count", 32'(hit_cnt), 32'(m_hit));
    chk("R6", "miss count", 32'(miss_cnt), 32'(m_miss));
    chk("R2", "flush strobes", {29'b0, cache_flush_o, lb_flush_o, sec_flush_o},
        {29'b0, m_cfl, m_lfl, m_sfl});
    chk("R4", "write error", 32'(wr_err_o), 32'(m_err));
  endtask

  // one clock: inputs applied now (near negedge), model updated at posedge
  task automatic tick(logic h, logic m, logic we, logic [31:0] wd, logic dn);
    logic acc, ev, clr;
    hit_pulse = h; miss_pulse = m; wr_en = we; wr_data = wd; cache_done = dn;
    @(posedge clk);
    acc = we && !m_busy;
    m_err = we && m_busy;
    m_cfl = acc && (wd[3] || (m_en && !wd[0]));
    m_lfl = acc && (wd[5] || (m_lb && !wd[4]));
    m_sfl = acc && wd[16];
    ev = m_cfl || m_lfl || m_sfl || (acc && ((m_en != wd[0]) || (m_lb != wd[4])));
    clr = acc && wd[8];
    if (clr) begin
      m_hit = '0; m_miss = '0;
    end else begin
      if (m_cne && h) m_hit = sat_inc(m_hit);
      if (m_cne && m) m_miss = sat_inc(m_miss);
    end
    if (m_init) begin
      if (m_tmr == 0) begin m_init = 1'b0; m_busy = 1'b0; end
      else m_tmr--;
    end else if (ev) begin
      m_busy = 1'b1; m_tmr = TMO - 1;
    end else if (m_busy) begin
      if (dn || m_tmr == 0) m_busy = 1'b0;
      else m_tmr--;
    end
    if (acc) begin
      m_en = wd[0]; m_lb = wd[4]; m_pol = wd[6]; m_cne = wd[7];
    end
    @(negedge clk);
    hit_pulse = 0; miss_pulse = 0; wr_en = 0; wr_data = 0; cache_done = 0;
    check_all();
  endtask

  task automatic do_reset();
    rst = 1; wr_en = 0; wr_data = 0; hit_pulse = 0; miss_pulse = 0; cache_done = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    m_en = 1; m_lb = 1; m_pol = 0; m_cne = 1; m_busy = 1; m_init = 1;
    m_tmr = RSTC - 1; m_hit = '0; m_miss = '0;
    m_cfl = 0; m_lfl = 0; m_sfl = 0; m_err = 0;
    chk("R1", "reset ctrl", ctrl_rdata, 32'h0000_0091);
    chk("R1", "reset status", 32'(stat_o), 32'h3);
    chk("R1", "reset counters", {hit_cnt, miss_cnt}, 32'h0);
    rst = 0;
  endtask

  task automatic idle_until_free();
    int guard;
    guard = 0;
    while (m_busy && guard < 200) begin
      tick(0, 0, 0, 32'h0, 1'b1);
      guard++;
    end
  endtask

  initial begin
    do_reset();
    // R8: busy for RST_CYC cycles, done ignored meanwhile
    for (int i = 0; i < RSTC - 1; i++) begin
      tick(0, 0, 0, 32'h0, 1'b1);
      chk("R8", "reset busy held", 32'(stat_o[1]), 32'h1);
    end
    tick(0, 0, 1, 32'h0000_0010, 1'b0);   // write in last init cycle: refused
    chk("R4", "refused in init", ctrl_rdata, 32'h0000_0091);
    chk("R8", "busy released", 32'(stat_o[1]), 32'h0);
    chk("R4", "error pulse", 32'(wr_err_o), 32'h1);
    tick(0, 0, 0, 32'h0, 1'b0);
    chk("R4", "error one cycle", 32'(wr_err_o), 32'h0);

    // R2: same value, flush bits 0: no strobe, no busy
    tick(1, 1, 1, 32'h0000_0091, 1'b0);
    chk("R2", "zero flush bits idle", 32'(stat_o[1]), 32'h0);
    chk("R2", "no cache strobe", 32'(cache_flush_o), 32'h0);
    // R9: policy change only
    tick(0, 0, 1, 32'h0000_00D1, 1'b0);
    chk("R9", "policy out", 32'(policy_o), 32'h1);
    chk("R5", "policy no busy", 32'(stat_o[1]), 32'h0);

    // R3: disable cache implies flush; done after 3 cycles
    tick(0, 0, 1, 32'h0000_00D0, 1'b0);
    chk("R3", "disable flushes", 32'(cache_flush_o), 32'h1);
    chk("R5", "busy set", 32'(stat_o[1]), 32'h1);
    tick(0, 0, 0, 32'h0, 1'b0);
    chk("R2", "strobe self-clears", 32'(cache_flush_o), 32'h0);
    tick(0, 0, 0, 32'h0, 1'b0);
    tick(0, 0, 0, 32'h0, 1'b1);
    chk("R5", "done clears busy", 32'(stat_o[1]), 32'h0);

    // R5: secure flush with no done: time-out after TMO cycles
    tick(0, 0, 1, 32'h0001_00D0, 1'b0);
    chk("R2", "secure strobe", 32'(sec_flush_o), 32'h1);
    chk("R2", "flush bits read 0", ctrl_rdata, 32'h0000_00D0);
    for (int i = 0; i < TMO - 1; i++) tick(0, 0, 0, 32'h0, 1'b0);
    chk("R5", "busy before time-out", 32'(stat_o[1]), 32'h1);
    tick(0, 0, 0, 32'h0, 1'b0);
    chk("R5", "time-out clears busy", 32'(stat_o[1]), 32'h0);

    // R3: line buffer disable flushes
    tick(0, 0, 1, 32'h0000_00C1, 1'b0);
    chk("R3", "lb disable flushes", 32'(lb_flush_o), 32'h1);
    idle_until_free();

    // R6: counting and saturation
    for (int i = 0; i < 300; i++) tick(1, i[0], 0, 32'h0, 1'b0);
    chk("R6", "hit saturates", 32'(hit_cnt), 32'(MAXV));
    // R6: counter enable off holds counts
    tick(0, 0, 1, 32'h0000_0051, 1'b0);
    idle_until_free();
    for (int i = 0; i < 5; i++) tick(1, 1, 0, 32'h0, 1'b0);
    chk("R6", "held when disabled", 32'(hit_cnt), 32'(MAXV));
    // R7: clear wins over same-cycle increment
    tick(0, 0, 1, 32'h0000_00D1, 1'b0);
    tick(1, 1, 1, 32'h0000_01D1, 1'b0);
    chk("R7", "clear hit", 32'(hit_cnt), 32'h0);
    chk("R7", "clear miss", 32'(miss_cnt), 32'h0);
    chk("R2", "clear bit reads 0", ctrl_rdata, 32'h0000_00D1);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] wd;
      logic we;
      we = ($urandom % 6) == 0;
      wd = $urandom & 32'h0001_01D1;
      if (($urandom % 4) == 0) wd |= ($urandom & 32'h0000_0028);
      if (($urandom % 16) == 0) wd = $urandom;
      tick(1'($urandom), 1'($urandom), we, wd, ($urandom % 5) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int s;
    s = $urandom(32'd1234);
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule